// File: doc/BRIEF.md
# PCI Interrupt Pin to ISA IRQ Router

This block takes four level-sensitive PCI interrupt request lines and steers each one onto one of sixteen ISA interrupt request outputs. Every pin has its own byte-wide routing register. A value below sixteen selects the ISA line with that number. A value of sixteen or more switches the pin off. Several pins may select the same ISA line, and that line is then the OR of all of them.

The four routing bytes share one 32-bit word of configuration space, at byte offset 0x60 (dword index 0x18). Byte lane *n* of that word holds the route for pin *n*. A simple register port reaches the word, with a byte enable on each lane. A separate query port takes a pin number and returns whether that pin is routed and, if so, to which IRQ. The ISA outputs follow the PIRQ levels combinationally. A route change written on a clock edge takes effect on the outputs from that edge on, and every output is re-evaluated against the new routes.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte reads 0x80, all ISA outputs are low whatever the PIRQ levels, and the query reports every pin as disabled with IRQ number 0.
- R2: A pin whose routing byte holds a value v below 16 drives ISA output v with its level, and the query for that pin returns enabled with IRQ number v (bits 3:0 of the byte).
- R3: A pin whose routing byte is 16 or more (for example 0x10, 0x8F or 0xFF) reaches no ISA output, and the query returns disabled with IRQ number 0.
- R4: Each ISA output is high exactly when at least one enabled pin routed to it is high, so pins that share a line act as a wired-OR.
- R5: A write to dword index 0x18 updates only the routing bytes whose byte enable is set (lane n, bits 8n+7:8n, belongs to pin n). Lanes with a clear enable keep their value.
- R6: Routing bytes read back exactly as written, including bits 7:4, on the read data when the address is dword index 0x18.
- R7: A write to any other dword index changes no routing byte, and a read at any other index returns zero.
- R8: A routing write takes effect on the clock edge that samples it, and the ISA outputs show the old routing before that edge. Changes on the PIRQ inputs reach the outputs in the same cycle.
- R9: When a route changes, the output the pin used to drive falls if no other pin holds it high, and the newly selected output follows the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data, lane n for pin n |
| cfg_rdata | output | 32 | Read data for the addressed dword |
| pirq_in | input | 4 | PCI interrupt request levels, bit n is pin n |
| irq_out | output | 16 | ISA interrupt request levels |
| query_pin | input | 2 | Pin number to query |
| query_en | output | 1 | Queried pin is routed |
| query_irq | output | 4 | IRQ the queried pin targets, 0 when disabled |

## Verification
The hardest case to reach is a shared ISA line in the middle of a reroute: one pin moves away from a line that another pin still holds high, and the line must stay up. The same line must fall when no other pin holds it. Disabled codes whose low nibble looks like a valid IRQ (0x8F, 0x1F) also need care. The random phase biases routing bytes toward small values so that collisions between pins are frequent, and it mixes in full-byte values and partial byte enables. Directed sequences place two pins on one line and then reroute one of them while both are held high.

// File: rtl/pirq_rt_pkg.sv
// Package for the PIRQ router: the routing byte type and the rule that
// decides whether a routing byte is enabled.
// Assumes: every routing entry is one byte wide.
package pirq_rt_pkg;

    localparam int unsigned ROUTE_W = 8;

    typedef logic [ROUTE_W-1:0] route_t;

    // A routing byte is enabled when its value is below the IRQ count.
    function automatic logic route_on(input route_t r, input int unsigned nirq);
        return 32'(r) < nirq;
    endfunction

endpackage

// File: rtl/pirq_route_regs.sv
// Holds one routing byte for each pin, all in a single configuration dword.
// Writes are applied per byte lane on the clock edge. The read data shows
// the dword when it is addressed and zero otherwise.
// Assumes: one lane per pin, ROUTE_W bits per lane.
module pirq_route_regs
    import pirq_rt_pkg::*;
#(
    parameter int unsigned NUM_PIN     = 4,
    parameter int unsigned ADDR_W      = 6,
    parameter logic [ADDR_W-1:0] ROUTE_DW = 6'h18,
    parameter route_t      RESET_ROUTE = 8'h80
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_PIN-1:0]              be,
    input  logic [NUM_PIN*ROUTE_W-1:0]      wdata,
    output logic [NUM_PIN*ROUTE_W-1:0]      rdata,
    output logic [NUM_PIN-1:0][ROUTE_W-1:0] route_q
);

    logic hit;

    // Address decode for the routing dword.
    assign hit = (addr == ROUTE_DW);

    // Read path: the addressed dword, or zero.
    assign rdata = hit ? route_q : '0;

    // R7
    other_addr_keeps_routes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit) |=> $stable(route_q));

    for (genvar i = 0; i < NUM_PIN; i++) begin : g_lane
        // Per-lane register with synchronous reset to the disabled code.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route_q[i] <= RESET_ROUTE;
            end else if (wr && hit && be[i]) begin
                route_q[i] <= wdata[i*ROUTE_W +: ROUTE_W];
            end
        end

        // R5
        masked_lane_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && hit && !be[i]) |=> $stable(route_q[i]));

        // R6
        lane_takes_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && hit && be[i]) |=> (route_q[i] == $past(wdata[i*ROUTE_W +: ROUTE_W])));
    end

endmodule

// File: rtl/pirq_level_map.sv
// Builds the pin-by-IRQ level matrix from the current routes and PIRQ
// levels. Bit irq*NUM_PIN+pin is set when that pin is enabled, routed to
// that IRQ, and high. Each IRQ output is the OR of its slice.
// Assumes: NUM_IRQ is a power of two that fits in a routing byte.
module pirq_level_map
    import pirq_rt_pkg::*;
#(
    parameter int unsigned NUM_PIN = 4,
    parameter int unsigned NUM_IRQ = 16
) (
    input  logic [NUM_PIN-1:0][ROUTE_W-1:0] route_q,
    input  logic [NUM_PIN-1:0]              pirq_in,
    output logic [NUM_IRQ-1:0]              irq_out
);

    localparam int unsigned IRQ_W = $clog2(NUM_IRQ);

    logic [NUM_PIN-1:0]         pin_en;
    logic [NUM_IRQ*NUM_PIN-1:0] level_vec;

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin_en
        // Enable decode for each pin's routing byte.
        assign pin_en[p] = route_on(route_q[p], NUM_IRQ);
    end

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
            // One matrix cell: pin p contributes to IRQ k.
            assign level_vec[k*NUM_PIN+p] = pin_en[p] && pirq_in[p] &&
                (route_q[p][IRQ_W-1:0] == IRQ_W'(k));
        end
        // Wired-OR of every pin landing on IRQ k.
        assign irq_out[k] = |level_vec[k*NUM_PIN +: NUM_PIN];
    end

endmodule

// File: rtl/pirq_route_query.sv
// Answers a route query for one pin: enabled flag and target IRQ number.
// The number reads zero when the pin is disabled.
// Assumes: query_pin is always a valid pin index.
module pirq_route_query
    import pirq_rt_pkg::*;
#(
    parameter int unsigned NUM_PIN = 4,
    parameter int unsigned NUM_IRQ = 16
) (
    input  logic [NUM_PIN-1:0][ROUTE_W-1:0] route_q,
    input  logic [$clog2(NUM_PIN)-1:0]      query_pin,
    output logic                            query_en,
    output logic [$clog2(NUM_IRQ)-1:0]      query_irq
);

    localparam int unsigned IRQ_W = $clog2(NUM_IRQ);

    route_t sel;

    // Select the queried pin's routing byte and report its decode.
    always_comb begin
        sel       = route_q[query_pin];
        query_en  = route_on(sel, NUM_IRQ);
        query_irq = query_en ? sel[IRQ_W-1:0] : '0;
    end

endmodule

// File: rtl/pirq_router.sv
// Top level of the PCI interrupt pin to ISA IRQ router. It ties together
// the routing registers, the level matrix and the query decoder.
// Assumes: routing writes are single-cycle strobes and the PIRQ inputs are
// already synchronous to clk.
module pirq_router
    import pirq_rt_pkg::*;
#(
    parameter int unsigned NUM_PIN     = 4,
    parameter int unsigned NUM_IRQ     = 16,
    parameter int unsigned ADDR_W      = 6,
    parameter logic [ADDR_W-1:0] ROUTE_DW = 6'h18,
    parameter logic [7:0]  RESET_ROUTE = 8'h80
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wr,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [NUM_PIN-1:0]           cfg_be,
    input  logic [NUM_PIN*8-1:0]         cfg_wdata,
    output logic [NUM_PIN*8-1:0]         cfg_rdata,
    input  logic [NUM_PIN-1:0]           pirq_in,
    output logic [NUM_IRQ-1:0]           irq_out,
    input  logic [$clog2(NUM_PIN)-1:0]   query_pin,
    output logic                         query_en,
    output logic [$clog2(NUM_IRQ)-1:0]   query_irq
);

    logic [NUM_PIN-1:0][ROUTE_W-1:0] route_q;

    pirq_route_regs #(
        .NUM_PIN     (NUM_PIN),
        .ADDR_W      (ADDR_W),
        .ROUTE_DW    (ROUTE_DW),
        .RESET_ROUTE (RESET_ROUTE)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .addr    (cfg_addr),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .route_q (route_q)
    );

    pirq_level_map #(
        .NUM_PIN (NUM_PIN),
        .NUM_IRQ (NUM_IRQ)
    ) map_i (
        .route_q (route_q),
        .pirq_in (pirq_in),
        .irq_out (irq_out)
    );

    pirq_route_query #(
        .NUM_PIN (NUM_PIN),
        .NUM_IRQ (NUM_IRQ)
    ) query_i (
        .route_q   (route_q),
        .query_pin (query_pin),
        .query_en  (query_en),
        .query_irq (query_irq)
    );

    // R2
    query_matches_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (query_en && pirq_in[query_pin]) |-> irq_out[query_irq]);

    // R3
    disabled_query_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !query_en |-> (query_irq == '0));

    // R4
    output_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> (|pirq_in));

endmodule

// File: tb/pirq_router_tb_top.sv
`timescale 1ns/1ps
module pirq_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = 6'h18;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic [3:0]  pirq_in = 4'h0;
    logic [15:0] irq_out;
    logic [1:0]  query_pin = 2'd0;
    logic        query_en;
    logic [3:0]  query_irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] m_route [4];

    always #2 clk = ~clk;

    pirq_router dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pirq_in   (pirq_in),
        .irq_out   (irq_out),
        .query_pin (query_pin),
        .query_en  (query_en),
        .query_irq (query_irq)
    );

    function automatic logic [15:0] exp_irq(input logic [3:0] pins);
        logic [15:0] r = '0;
        for (int p = 0; p < 4; p++)
            if (m_route[p] < 8'd16 && pins[p]) r[m_route[p][3:0]] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] exp_word();
        return {m_route[3], m_route[2], m_route[1], m_route[0]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s got %h expected %h", req, what, act, exp);
        end
    endtask

    // Called in the low phase with the write strobe idle and addr = 0x18.
    task automatic check_state(input string req);
        #0.4;
        chk(req, "irq_out", 32'(irq_out), 32'(exp_irq(pirq_in)));
        chk(req, "rdata", cfg_rdata, exp_word());
        for (int p = 0; p < 4; p++) begin
            query_pin = 2'(p);
            #0.3;
            chk(req, "query_en", 32'(query_en), 32'(m_route[p] < 8'd16));
            chk(req, "query_irq", 32'(query_irq),
                32'(m_route[p] < 8'd16 ? m_route[p][3:0] : 4'd0));
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [3:0] be,
                            input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        #1;
        // R8: old routing still visible before the edge
        chk("R8", "irq_out before edge", 32'(irq_out), 32'(exp_irq(pirq_in)));
        if (a == 6'h18)
            for (int i = 0; i < 4; i++)
                if (be[i]) m_route[i] = d[i*8 +: 8];
        @(negedge clk);
        cfg_wr = 1'b0; cfg_addr = 6'h18; cfg_be = 4'h0;
    endtask

    task automatic set_pins(input logic [3:0] v, input string req);
        @(negedge clk);
        pirq_in = v;
        check_state(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) m_route[i] = 8'h80;
        check_state("R1");
        chk("R1", "rdata reset word", cfg_rdata, 32'h80808080);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < 4; i++) m_route[i] = 8'h80;
        pirq_in = 4'hF;
        do_reset();

        // R2: pin 0 to IRQ 5
        do_write(6'h18, 4'b0001, 32'h0000_0005);
        check_state("R2");
        chk("R2", "irq5 high", 32'(irq_out), 32'h0020);
        set_pins(4'h0, "R8");
        chk("R8", "irq low with pin low", 32'(irq_out), 32'h0);

        // R4: pins 1 and 2 share IRQ 9
        do_write(6'h18, 4'b0110, 32'h0009_0900);
        set_pins(4'b0010, "R4");
        chk("R4", "shared irq9 one pin", 32'(irq_out), 32'h0200);
        set_pins(4'b0110, "R4");
        chk("R4", "shared irq9 two pins", 32'(irq_out), 32'h0200);

        // R9: move pin 1 away while pin 2 still holds IRQ 9
        do_write(6'h18, 4'b0010, 32'h0000_0B00);
        check_state("R9");
        chk("R9", "irq9 held by pin2, irq11 up", 32'(irq_out), 32'h0A00);
        do_write(6'h18, 4'b0100, 32'h0003_0000);
        check_state("R9");
        chk("R9", "irq9 released", 32'(irq_out), 32'h0808);

        // R3: disabled codes whose low nibble looks valid
        pirq_in = 4'hF;
        do_write(6'h18, 4'b1111, 32'hFF8F_1F10);
        check_state("R3");
        chk("R3", "no outputs", 32'(irq_out), 32'h0);

        // R6: full byte readback
        do_write(6'h18, 4'b1111, 32'hF3A2_0C07);
        check_state("R6");
        chk("R6", "readback", cfg_rdata, 32'hF3A2_0C07);

        // R5: partial lanes
        do_write(6'h18, 4'b0101, 32'hAABB_CC01);
        check_state("R5");
        chk("R5", "lanes 0 and 2 only", cfg_rdata, 32'hF3BB_0C01);

        // R7: other addresses
        do_write(6'h19, 4'b1111, 32'h0000_0000);
        do_write(6'h17, 4'b1111, 32'h0101_0101);
        check_state("R7");
        chk("R7", "routes unchanged", cfg_rdata, 32'hF3BB_0C01);
        @(negedge clk);
        cfg_addr = 6'h19;
        #0.5;
        chk("R7", "read other addr zero", cfg_rdata, 32'h0);
        cfg_addr = 6'h18;

        // R1: reset mid-run clears routes
        do_reset();

        // Random phase
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r = $urandom;
            logic [31:0] d;
            logic [5:0]  a;
            for (int i = 0; i < 4; i++) begin
                logic [31:0] b = $urandom;
                d[i*8 +: 8] = b[8] ? b[7:0] : {4'h0, b[3:0]};
            end
            a = (r[1:0] != 2'd0) ? 6'h18 : r[7:2];
            do_write(a, r[11:8], d);
            set_pins(r[15:12], "R4");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule